// File: doc/BRIEF.md
# PCM Serial Word Port

This block is a full-duplex serial port for a PCM/TDM link. It is a slave: a bit clock and a frame-sync pulse come from outside, along with a serial data input. The block drives a serial data output. Each frame carries one 16-bit word in each direction. The transmit word is taken from a parallel input when the frame starts. The received word is handed out on a parallel output with a single-cycle strobe.

The block runs on a fast system clock. The bit clock, frame sync and serial input are brought into that clock through synchronizer chains, and the block acts on the detected bit-clock edges. Outgoing bits change after a rising bit-clock edge. Incoming bits and the frame sync are sampled on the falling edge, so each bit is read in the middle of its period.

Top module: `pcm_serial_port`

## Requirements
- R1: While rst_n is low, and right after it is released, sdout, rx_valid and rx_data are all 0. This also holds when reset is asserted in the middle of a frame.
- R2: A frame starts when fsync is sampled high on a falling bit-clock edge. tx_data is captured at that moment. Changes to tx_data later in the frame do not alter the bits sent.
- R3: The transmit word is sent MSB first. Its MSB appears on sdout after the rising bit-clock edge that begins the bit period following the frame-sync period. Each following rising edge presents the next lower bit.
- R4: After all 16 bits of a word have been sent, sdout is 0 in every later bit period until a new frame starts.
- R5: sdin is sampled on the falling bit-clock edge of each of the 16 bit periods after the frame-sync period. The first sampled bit becomes rx_data bit 15 and the last becomes bit 0.
- R6: rx_valid is high for exactly one system-clock cycle per completed word, in the same cycle that rx_data takes the new word. rx_data holds its value at all other times.
- R7: If fsync is sampled high before all 16 bits have been received, the partial word is dropped with no rx_valid and a new frame starts in both directions. This includes the case where fsync arrives on the edge that would have sampled the 16th bit.
- R8: If fsync is sampled high in the bit period directly after the 16th bit, the previous word is still delivered and the new frame runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame-sync pulse, about one bit period wide |
| sdin | input | 1 | Serial receive data |
| tx_data | input | 16 | Word to transmit, captured at frame start |
| sdout | output | 1 | Serial transmit data |
| rx_data | output | 16 | Last completed received word |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_data |

## Verification
Frame start and word completion both happen on a falling bit-clock edge, so one edge can call for both. The bench provokes this in two ways. In the first, fsync is placed in the slot of the 16th data bit; the bench must then see no strobe for the dropped word and a correct next frame. In the second, fsync is placed one slot later; the bench must then see the old word delivered and the new frame start cleanly in both directions. A frame cut short after eight bits is checked in the same way: the strobe count must stay unchanged, and both directions must restart from the new word's MSB.

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int W    = 16,
  parameter int SYNC = 2,
  localparam int CW  = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         fsync,
  input  logic         sdin,
  input  logic [W-1:0] tx_data,
  output logic         sdout,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);

  logic [SYNC-1:0] b_sy, f_sy, d_sy;
  logic            b_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sy <= '0;
      f_sy <= '0;
      d_sy <= '0;
      b_d  <= 1'b0;
    end else begin
      b_sy <= {b_sy[SYNC-2:0], bclk};
      f_sy <= {f_sy[SYNC-2:0], fsync};
      d_sy <= {d_sy[SYNC-2:0], sdin};
      b_d  <= b_sy[SYNC-1];
    end
  end

  wire b_s  = b_sy[SYNC-1];
  wire fs_s = f_sy[SYNC-1];
  wire di_s = d_sy[SYNC-1];
  wire rise = b_s & ~b_d;
  wire fall = ~b_s & b_d;
  wire start = fall & fs_s;

  logic [W-1:0]  tx_sh;
  logic [CW-1:0] tx_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_left <= '0;
      sdout   <= 1'b0;
    end else if (start) begin
      tx_sh   <= tx_data;
      tx_left <= CW'(W);
    end else if (rise) begin
      if (tx_left != '0) begin
        sdout   <= tx_sh[W-1];
        tx_sh   <= {tx_sh[W-2:0], 1'b0};
        tx_left <= tx_left - 1'b1;
      end else begin
        sdout   <= 1'b0;
      end
    end
  end

  logic [W-1:0]  rx_sh;
  logic [CW-1:0] rx_cnt;
  logic          rx_on;
  wire           rx_last = rx_on && (rx_cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_cnt   <= '0;
      rx_on    <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start) begin
        rx_cnt <= '0;
        rx_on  <= 1'b1;
      end else if (fall && rx_on) begin
        rx_sh  <= {rx_sh[W-2:0], di_s};
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_last) begin
          rx_data  <= {rx_sh[W-2:0], di_s};
          rx_valid <= 1'b1;
          rx_on    <= 1'b0;
        end
      end
    end
  end

endmodule

module pcm_serial_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rise,
  input logic         fall,
  input logic         sdout,
  input logic [W-1:0] rx_data,
  input logic         rx_valid
);

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  assert_sdout_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(rise));

  assert_word_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall));

endmodule

bind pcm_serial_port pcm_serial_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
  .sdout(sdout), .rx_data(rx_data), .rx_valid(rx_valid)
);

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;
  logic clk = 0, rst_n = 0, bclk = 0, fsync = 0, sdin = 0;
  logic [15:0] tx_data = '0;
  logic sdout, rx_valid;
  logic [15:0] rx_data;

  int checks = 0, errors = 0, vcount = 0;
  logic [15:0] rx_got = '0;

  always #10 clk = ~clk;

  pcm_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
    .tx_data(tx_data), .sdout(sdout), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) if (rx_valid) begin
    vcount++;
    rx_got = rx_data;
  end

  localparam logic [31:0] VEC [5] = '{
    {16'hA5C3, 16'h3C5A}, {16'hFFFF, 16'h0000}, {16'h0000, 16'hFFFF},
    {16'h8001, 16'h1234}, {16'h7FFE, 16'hBEEF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bitp(input logic fs, input logic din, output logic so);
    @(negedge clk); bclk = 1; fsync = fs; sdin = din;
    repeat (7) @(negedge clk);
    so = sdout;
    @(negedge clk); bclk = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] rxw, input int nbits, output logic [15:0] got);
    logic so;
    got = '0;
    bitp(1'b1, 1'b0, so);
    for (int i = 0; i < nbits; i++) begin
      bitp(1'b0, rxw[15-i], so);
      got[15-i] = so;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] got;
    logic so;
    int base;
    repeat (5) @(negedge clk);
    chk("R1 sdout in reset", sdout, 0);
    chk("R1 rx_valid in reset", rx_valid, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 rx_data after reset", rx_data, 0);
    chk("R1 sdout after reset", sdout, 0);

    for (int v = 0; v < 5; v++) begin
      tx_data = VEC[v][31:16];
      base = vcount;
      frame(VEC[v][15:0], 16, got);
      chk("R3 tx word", got, VEC[v][31:16]);
      chk("R6 one strobe", vcount, base + 1);
      chk("R5 rx word", rx_got, VEC[v][15:0]);
      bitp(1'b0, 1'b1, so);
      chk("R4 idle low 1", so, 0);
      bitp(1'b0, 1'b1, so);
      chk("R4 idle low 2", so, 0);
    end

    // R2: tx_data changed after frame start is ignored
    tx_data = 16'h1357;
    bitp(1'b1, 1'b0, so);
    tx_data = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      bitp(1'b0, 1'b0, so);
      got[15-i] = so;
    end
    chk("R2 latched word", got, 16'h1357);
    bitp(1'b0, 1'b0, so);

    // R7: abandon after 8 bits
    tx_data = 16'hF0F0;
    base = vcount;
    frame(16'hAAAA, 8, got);
    chk("R7 partial tx bits", got[15:8], 8'hF0);
    chk("R7 no strobe on abandon", vcount, base);
    tx_data = 16'h0F0F;
    frame(16'h5555, 16, got);
    chk("R7 restart tx", got, 16'h0F0F);
    chk("R7 restart rx", rx_got, 16'h5555);
    chk("R7 strobe count", vcount, base + 1);
    bitp(1'b0, 1'b0, so);

    // R7: fsync in slot of 16th bit
    tx_data = 16'h2222;
    base = vcount;
    frame(16'h6666, 15, got);
    chk("R7 no strobe at 15 bits", vcount, base);
    tx_data = 16'hC3C3;
    frame(16'h9A9A, 16, got);
    chk("R7 collision tx", got, 16'hC3C3);
    chk("R7 collision rx", rx_got, 16'h9A9A);
    chk("R7 collision count", vcount, base + 1);
    bitp(1'b0, 1'b0, so);

    // R8: back-to-back frames
    tx_data = 16'h4444;
    base = vcount;
    frame(16'h1111, 16, got);
    chk("R8 first rx", rx_got, 16'h1111);
    tx_data = 16'hDEAD;
    frame(16'hCAFE, 16, got);
    chk("R8 second tx", got, 16'hDEAD);
    chk("R8 second rx", rx_got, 16'hCAFE);
    chk("R8 count", vcount, base + 2);
    bitp(1'b0, 1'b0, so);
    chk("R4 after back-to-back", so, 0);

    // R1: reset mid-frame
    tx_data = 16'hFFFF;
    frame(16'h0000, 4, got);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 sdout mid-frame reset", sdout, 0);
    chk("R1 rx_data mid-frame reset", rx_data, 0);
    rst_n = 1;
    bitp(1'b0, 1'b0, so);
    chk("R1 stays idle", so, 0);

    finish_run();
  end
endmodule